// File: doc/BRIEF.md
# SD SPI Data Block Mover

This unit carries one data block between a byte buffer and a memory card that is on an SPI link, once a separate command unit has sent a read or write command and the card has accepted it. It never shifts bits itself. Each byte goes through an external byte-exchange engine with a request/acknowledge pair: the unit holds `xfer_req` high with a stable `xfer_tx`, and the engine pulses `xfer_ack` for one cycle when the exchange is complete, with the received byte on `xfer_rx`.

For a read, the unit polls the card until the data start marker arrives. It passes each payload byte to the buffer as it arrives, and then compares the two trailing check bytes with a CRC-16 that it computes on the fly. For a write, the unit polls until the card is no longer busy. It then sends the start marker, the payload taken from the buffer one byte at a time, and the check bytes, and decodes the card's data-response byte. A separate operation sends the single marker byte that closes a multi-block write. Because the CRC is updated as each byte passes, the unit stores no payload.

Each operation ends with a one-cycle `done` pulse and a 2-bit result code: 0 success, 1 timeout, 2 protocol/IO error, 3 CRC mismatch.

Top module: `sd_block_xfer`

## Requirements
- R1: After reset, `busy`, `done`, `xfer_req`, `rd_valid`, `wr_take` are 0 and `err_code` is 0.
- R2: Read (`op`=0): every byte the unit sends is 0xFF. Received 0xFF bytes are skipped while waiting. A received 0xFE starts the payload. The next `len` received bytes appear in order on `rd_data`, each with a one-cycle `rd_valid`.
- R3: Read: during the wait, a received byte that is neither 0xFF nor 0xFE ends the operation with result 2, and no `rd_valid` occurs.
- R4: A wait phase ends with result 1 once `TIMEOUT_POLLS` consecutive non-terminating polls have been received. For a read, those are 0xFF bytes. For a write, those are non-0xFF bytes. Exactly `TIMEOUT_POLLS` exchanges occur in that case.
- R5: Read: the two bytes after the payload form the received CRC, high byte first. With `crc_en`=1 a mismatch gives result 3. With `crc_en`=0 the check bytes are ignored and the result is 0.
- R6: The CRC is CRC-16 with polynomial 0x1021 and initial value 0, processed MSB first over the payload bytes only.
- R7: Write (`op`=1 single, `op`=2 one block of a multi-block write): the unit sends 0xFF until it receives 0xFF. It then sends 0xFE (single) or 0xFC (multi), then `len` bytes taken from `wr_data`. `wr_take` pulses once as each byte's exchange completes.
- R8: Write: after the payload the unit sends the computed CRC, high byte first, when `crc_en`=1, and 0xFF 0xFF when `crc_en`=0.
- R9: Write: one more byte is then received. If its low 5 bits equal 0x05, the result is 0; otherwise it is 2.
- R10: Stop (`op`=3): exactly one exchange, sending 0xFD, then result 0.
- R11: `start` in idle makes `busy` high on the next cycle. `start` while `busy` is ignored.
- R12: `done` is a one-cycle pulse with `busy` low, `err_code` is 0 whenever `done` is low, and `xfer_tx` stays stable while `xfer_req` is held without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 2 | 0 read, 1 single write, 2 multi-block write block, 3 stop marker |
| len | input | LEN_W | Payload length in bytes, 1..MAX_LEN, sampled at start |
| crc_en | input | 1 | Enable CRC check (read) / CRC generation (write) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result, valid with done |
| xfer_req | output | 1 | Byte exchange request to the SPI engine |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange complete pulse |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| rd_valid | output | 1 | Read payload byte valid |
| rd_data | output | 8 | Read payload byte |
| wr_data | input | 8 | Current write payload byte from buffer |
| wr_take | output | 1 | Current write byte consumed; buffer advances |

## Verification
The checker watches the handshake rules on every cycle: the shape of the `done` pulse and the silence of the result code outside it, the hold of `xfer_tx` until it is acknowledged, the rule that buffer strobes occur only on an acknowledge, the acceptance of `start` from idle, and the bound on the poll counter. Token values, payload order, CRC arithmetic, the data-response decode and the choice of result code depend on the byte streams involved. Only the bench scenarios show these, by scripting card replies and comparing every sent and received byte with values computed independently.

// File: rtl/sd_block_pkg.sv
`timescale 1ns/1ps
package sd_block_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WR_ONE = 2'd1, OP_WR_MANY = 2'd2, OP_END = 2'd3} op_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_TIMEOUT = 2'd1, RES_IO = 2'd2, RES_CRC = 2'd3} res_e;

  localparam logic [7:0] BYTE_IDLE = 8'hFF;
  localparam logic [7:0] MARK_ONE  = 8'hFE;
  localparam logic [7:0] MARK_MANY = 8'hFC;
  localparam logic [7:0] MARK_END  = 8'hFD;
  localparam logic [4:0] ACK_GOOD  = 5'h05;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // One byte of CRC-16, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_block_crc16.sv
`timescale 1ns/1ps
module sd_block_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import sd_block_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/sd_block_poll_timer.sv
`timescale 1ns/1ps
module sd_block_poll_timer #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = tick && (count == W'(LIMIT - 1));
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + W'(1);
  end
endmodule

// File: rtl/sd_block_xfer.sv
`timescale 1ns/1ps
module sd_block_xfer #(
  parameter int MAX_LEN       = 512,
  parameter int TIMEOUT_POLLS = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int PC_W  = $clog2(TIMEOUT_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [LEN_W-1:0] len,
  input  logic             crc_en,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic [7:0]       wr_data,
  output logic             wr_take
);
  import sd_block_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_WAIT, S_RD_DATA, S_RD_CRCH, S_RD_CRCL,
    S_WR_WAIT, S_WR_MARK, S_WR_DATA, S_WR_CRCH, S_WR_CRCL, S_WR_RESP, S_END_MARK
  } st_e;

  st_e              state, state_n;
  logic             multi_q, crc_en_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [7:0]       crc_hi_q;
  logic             done_q;
  res_e             res_q;

  // Named internal events
  logic             accept, rx_idle, last_byte, poll_tick, poll_expire;
  logic             finish, crc_upd;
  res_e             fin_res;
  logic [15:0]      crc_val;
  logic [PC_W-1:0]  poll_cnt;
  logic [7:0]       crc_din;

  assign accept    = start && (state == S_IDLE);
  assign rx_idle   = (xfer_rx == BYTE_IDLE);
  assign last_byte = (cnt_q == len_q - LEN_W'(1));
  assign poll_tick = xfer_ack && (((state == S_RD_WAIT) && rx_idle) ||
                                  ((state == S_WR_WAIT) && !rx_idle));
  assign crc_upd   = xfer_ack && ((state == S_RD_DATA) || (state == S_WR_DATA));
  assign crc_din   = (state == S_RD_DATA) ? xfer_rx : wr_data;

  sd_block_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(crc_upd), .din(crc_din), .crc(crc_val)
  );

  sd_block_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(poll_tick),
    .count(poll_cnt), .expire(poll_expire)
  );

  always_comb begin
    state_n = state;
    finish  = 1'b0;
    fin_res = RES_OK;
    if (state == S_IDLE) begin
      if (start) begin
        unique case (op_e'(op))
          OP_READ:    state_n = S_RD_WAIT;
          OP_WR_ONE,
          OP_WR_MANY: state_n = S_WR_WAIT;
          default:    state_n = S_END_MARK;
        endcase
      end
    end else if (xfer_ack) begin
      unique case (state)
        S_RD_WAIT: begin
          if (xfer_rx == MARK_ONE) state_n = S_RD_DATA;
          else if (!rx_idle) begin finish = 1'b1; fin_res = RES_IO; end
          else if (poll_expire) begin finish = 1'b1; fin_res = RES_TIMEOUT; end
        end
        S_RD_DATA: if (last_byte) state_n = S_RD_CRCH;
        S_RD_CRCH: state_n = S_RD_CRCL;
        S_RD_CRCL: begin
          finish  = 1'b1;
          fin_res = (crc_en_q && ({crc_hi_q, xfer_rx} != crc_val)) ? RES_CRC : RES_OK;
        end
        S_WR_WAIT: begin
          if (rx_idle) state_n = S_WR_MARK;
          else if (poll_expire) begin finish = 1'b1; fin_res = RES_TIMEOUT; end
        end
        S_WR_MARK: state_n = S_WR_DATA;
        S_WR_DATA: if (last_byte) state_n = S_WR_CRCH;
        S_WR_CRCH: state_n = S_WR_CRCL;
        S_WR_CRCL: state_n = S_WR_RESP;
        S_WR_RESP: begin
          finish  = 1'b1;
          fin_res = (xfer_rx[4:0] == ACK_GOOD) ? RES_OK : RES_IO;
        end
        default:   finish = 1'b1;
      endcase
      if (finish) state_n = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      multi_q  <= 1'b0;
      crc_en_q <= 1'b0;
      len_q    <= '0;
      cnt_q    <= '0;
      crc_hi_q <= '0;
      done_q   <= 1'b0;
      res_q    <= RES_OK;
    end else begin
      state  <= state_n;
      done_q <= finish;
      res_q  <= finish ? fin_res : RES_OK;
      if (accept) begin
        multi_q  <= (op_e'(op) == OP_WR_MANY);
        crc_en_q <= crc_en;
        len_q    <= len;
        cnt_q    <= '0;
      end
      if (crc_upd) cnt_q <= cnt_q + LEN_W'(1);
      if (xfer_ack && (state == S_RD_CRCH)) crc_hi_q <= xfer_rx;
    end
  end

  always_comb begin
    unique case (state)
      S_WR_MARK:  xfer_tx = multi_q ? MARK_MANY : MARK_ONE;
      S_WR_DATA:  xfer_tx = wr_data;
      S_WR_CRCH:  xfer_tx = crc_en_q ? crc_val[15:8] : BYTE_IDLE;
      S_WR_CRCL:  xfer_tx = crc_en_q ? crc_val[7:0]  : BYTE_IDLE;
      S_END_MARK: xfer_tx = MARK_END;
      default:    xfer_tx = BYTE_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign xfer_req = busy;
  assign done     = done_q;
  assign err_code = res_q;
  assign rd_valid = xfer_ack && (state == S_RD_DATA);
  assign rd_data  = xfer_rx;
  assign wr_take  = xfer_ack && (state == S_WR_DATA);
endmodule

// File: rtl/sd_block_xfer_chk.sv
`timescale 1ns/1ps
module sd_block_xfer_chk #(
  parameter int LIMIT = 16,
  parameter int PC_W  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [1:0]      err_code,
  input logic            xfer_req,
  input logic            xfer_ack,
  input logic [7:0]      xfer_tx,
  input logic            rd_valid,
  input logic            wr_take,
  input logic [PC_W-1:0] poll_cnt
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (err_code == 2'd0)); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx))); // R12
  AST_RD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (xfer_ack && !wr_take)); // R2
  AST_TAKE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> xfer_ack); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R11
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PC_W'(LIMIT)); // R4
endmodule

bind sd_block_xfer sd_block_xfer_chk #(.LIMIT(TIMEOUT_POLLS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx),
  .rd_valid(rd_valid), .wr_take(wr_take), .poll_cnt(poll_cnt)
);

// File: tb/sd_block_xfer_test.sv
`timescale 1ns/1ps
module sd_block_xfer_test;
  localparam int MAX_LEN = 512;
  localparam int TMO     = 16;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [LEN_W-1:0] len = '0;
  logic crc_en = 1'b0;
  logic busy, done, xfer_req, rd_valid, wr_take;
  logic [1:0] err_code;
  logic [7:0] xfer_tx, rd_data, wr_data;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rx = 8'hFF;

  int total = 0, bad = 0;
  logic [7:0] resp[$];
  logic [7:0] sent[$];
  logic [7:0] got[$];
  int done_cnt = 0, take_cnt = 0, wr_idx = 0, wr_seed = 0;
  logic [1:0] last_err = '0;
  bit take_pend = 0;

  always #2.5 clk = ~clk;

  sd_block_xfer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .len(len), .crc_en(crc_en),
    .busy(busy), .done(done), .err_code(err_code), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_data(wr_data), .wr_take(wr_take)
  );

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 7 + s * 13 + 3) ^ (i >> 3));
  endfunction

  assign wr_data = pat(wr_idx, wr_seed);

  // Independent CRC model: byte-swap / nibble-fold formulation.
  function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
    logic [15:0] c = 16'h0;
    foreach (b[k]) begin
      c = {c[7:0], c[15:8]};
      c = c ^ {8'h00, b[k]};
      c = c ^ {12'h000, c[7:4]};
      c = c ^ {c[3:0], 12'h000};
      c = c ^ {3'b000, c[7:0], 5'b00000};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Card model: two cycles per exchange.
  initial begin
    forever begin
      @(posedge clk); #1;
      xfer_ack = 1'b0;
      if (xfer_req) begin
        @(posedge clk); #1;
        xfer_rx  = (resp.size() > 0) ? resp.pop_front() : 8'hFF;
        xfer_ack = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (xfer_ack && xfer_req) sent.push_back(xfer_tx);
    if (rd_valid) got.push_back(rd_data);
    if (wr_take) begin take_cnt++; take_pend = 1; end
    if (done) begin done_cnt++; last_err = err_code; end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (take_pend) begin wr_idx++; take_pend = 0; end
    end
  end

  task automatic clear_obs();
    sent.delete(); got.delete();
    done_cnt = 0; take_cnt = 0; wr_idx = 0;
  endtask

  task automatic kick(input logic [1:0] o, input int n, input bit ce);
    @(posedge clk); #1;
    start = 1'b1; op = o; len = LEN_W'(n); crc_en = ce;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0 && done_cnt == 1, "R12 done single pulse", done_cnt, 1);
  endtask

  task automatic t_reset();
    check(!busy && !done && !xfer_req && !rd_valid && !wr_take && err_code == 2'd0,
          "R1 reset outputs", {busy, done, xfer_req, err_code}, 0);
  endtask

  task automatic t_read(input int n, input int seed, input bit ce, input bit corrupt, input int exp_err);
    logic [7:0] pl[$];
    logic [15:0] c;
    int ff_bad = 0, mism = 0;
    clear_obs();
    for (int i = 0; i < n; i++) pl.push_back(pat(i, seed));
    c = ref_crc(pl);
    if (corrupt) c = c ^ 16'h0100;
    resp = {8'hFF, 8'hFF, 8'hFE};
    foreach (pl[i]) resp.push_back(pl[i]);
    resp.push_back(c[15:8]); resp.push_back(c[7:0]);
    kick(2'd0, n, ce);
    wait_done();
    foreach (sent[i]) if (sent[i] != 8'hFF) ff_bad++;
    check(ff_bad == 0, "R2 read sends only FF", ff_bad, 0);
    check(got.size() == n, "R2 read payload count", got.size(), n);
    foreach (got[i]) if (i < n && got[i] != pl[i]) mism++;
    check(mism == 0, "R2 read payload order", mism, 0);
    check(int'(last_err) == exp_err, "R5 R6 read result", last_err, exp_err);
  endtask

  task automatic t_read_io();
    clear_obs();
    resp = {8'hFF, 8'h3C};
    kick(2'd0, 16, 1'b1);
    wait_done();
    check(last_err == 2'd2, "R3 bad marker result", last_err, 2);
    check(got.size() == 0, "R3 no payload", got.size(), 0);
    check(sent.size() == 2, "R3 stops at bad marker", sent.size(), 2);
  endtask

  task automatic t_read_timeout();
    clear_obs();
    resp.delete();
    kick(2'd0, 16, 1'b1);
    wait_done();
    check(last_err == 2'd1, "R4 read timeout result", last_err, 1);
    check(sent.size() == TMO, "R4 read poll count", sent.size(), TMO);
  endtask

  task automatic t_write(input bit multi, input bit ce, input logic [7:0] ack_byte, input int exp_err);
    logic [7:0] pl[$];
    logic [15:0] c;
    int n = 16, mism = 0;
    clear_obs();
    wr_seed = multi ? 5 : 9;
    for (int i = 0; i < n; i++) pl.push_back(pat(i, wr_seed));
    c = ce ? ref_crc(pl) : 16'hFFFF;
    resp = {8'h00, 8'h00, 8'hFF};
    for (int i = 0; i < n + 3; i++) resp.push_back(8'hFF);
    resp.push_back(ack_byte);
    kick(multi ? 2'd2 : 2'd1, n, ce);
    wait_done();
    check(sent.size() == 3 + 1 + n + 3, "R7 write exchange count", sent.size(), n + 7);
    if (sent.size() == n + 7) begin
      check(sent[0] == 8'hFF && sent[2] == 8'hFF, "R7 busy polls send FF", sent[2], 8'hFF);
      check(sent[3] == (multi ? 8'hFC : 8'hFE), "R7 start marker", sent[3], multi ? 8'hFC : 8'hFE);
      for (int i = 0; i < n; i++) if (sent[4 + i] != pl[i]) mism++;
      check(mism == 0, "R7 payload bytes", mism, 0);
      check({sent[4 + n], sent[5 + n]} == c, "R6 R8 write check bytes", {sent[4 + n], sent[5 + n]}, c);
    end
    check(take_cnt == n, "R7 wr_take count", take_cnt, n);
    check(int'(last_err) == exp_err, "R9 data response result", last_err, exp_err);
  endtask

  task automatic t_write_timeout();
    clear_obs();
    resp.delete();
    for (int i = 0; i < TMO + 4; i++) resp.push_back(8'h00);
    kick(2'd1, 16, 1'b1);
    wait_done();
    check(last_err == 2'd1, "R4 write busy timeout", last_err, 1);
    check(sent.size() == TMO, "R4 write poll count", sent.size(), TMO);
    check(take_cnt == 0, "R4 no payload taken", take_cnt, 0);
    resp.delete();
  endtask

  task automatic t_stop();
    clear_obs();
    kick(2'd3, 16, 1'b1);
    wait_done();
    check(sent.size() == 1, "R10 stop exchange count", sent.size(), 1);
    if (sent.size() == 1) check(sent[0] == 8'hFD, "R10 stop marker", sent[0], 8'hFD);
    check(last_err == 2'd0, "R10 stop result", last_err, 0);
  endtask

  task automatic t_start_busy();
    int mism = 0;
    clear_obs();
    resp = {8'hFF, 8'hFE};
    for (int i = 0; i < 4; i++) resp.push_back(pat(i, 2));
    resp.push_back(8'h00); resp.push_back(8'h00);
    kick(2'd0, 4, 1'b0);
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    repeat (3) @(posedge clk);
    #1; start = 1'b1; op = 2'd3; len = LEN_W'(2);
    @(posedge clk); #1; start = 1'b0;
    wait_done();
    foreach (sent[i]) if (sent[i] != 8'hFF) mism++;
    check(mism == 0, "R11 no stop marker sent", mism, 0);
    check(got.size() == 4, "R11 read length kept", got.size(), 4);
    check(last_err == 2'd0, "R11 read result", last_err, 0);
    repeat (6) @(negedge clk);
    check(!busy && done_cnt == 1, "R11 no second operation", done_cnt, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(16, 1, 1'b1, 1'b0, 0);
    t_read(16, 4, 1'b1, 1'b1, 3);
    t_read(16, 6, 1'b0, 1'b1, 0);
    t_read(MAX_LEN, 3, 1'b1, 1'b0, 0);
    t_read_io();
    t_read_timeout();
    t_write(1'b0, 1'b1, 8'hE5, 0);
    t_write(1'b1, 1'b0, 8'h0B, 2);
    t_write(1'b1, 1'b1, 8'h05, 0);
    t_write_timeout();
    t_stop();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule